// File: doc/BRIEF.md
# Timer channel pin action resolver

This block holds the pin-side action logic of a single timer channel. Two comparator match strobes come in from outside, together with one asynchronous input pin. The block drives one output pin. Each of the two events has a 3-bit output action code and a 3-bit input action code. The output code says what the event does to the output pin. The input code says which input-pin condition counts as that event's transition.

An output code with its top bit set waits for the event's input transition rather than the match. This lets an input edge move the output with no processor involvement, which supports fast short-circuit shutoff of a driver. When both events occur in one cycle, a channel-mode priority picks the prevailing event. If the prevailing event's code is "no action", the pin does not change at all.

A window mode opens an input window on match1 and closes it on match2. It samples the input when the window closes, which produces input-gated pulses. The block also registers the transition flags and a service request raised by an accepted match2.

Top module: `tmr_pin_action`

## Requirements
- R1: After reset, `pin_out` equals the RESET_LEVEL parameter (default 0) and `trans1`, `trans2` and `svc_req` are 0.
- R2: Output codes act on the clock edge that samples the event. 000 has no effect, 001 drives high, 010 drives low and 011 toggles. With no event the pin holds its level.
- R3: Output codes 1xx act only on the event's input transition and never on the bare match. 101 drives high, 100 and 110 drive low, and 111 toggles.
- R4: Input code 001 marks a rising edge, 010 a falling edge and 011 either edge. 100 marks a match seen while the synchronised input is low. Other codes never mark one. A marked transition raises `trans1`/`trans2` for one cycle, one edge later. An input change is seen three rising edges after it is applied (two-stage synchroniser plus edge register).
- R5: When both events occur in one cycle, event 1's code prevails in mode 0 (single), 1 (blocking) and 2 (both-match). Event 2's code prevails in mode 3 (match2-only). An event occurs when it has a match or a marked transition.
- R6: In mode 5 (user), event 2 prevails when `m2_blocks_m1`=1 and `m1_blocks_m2`=0. In every other flag combination event 1 prevails.
- R7: When both events occur and the prevailing code is 000, `pin_out` is unchanged. This holds even if the other event's action is triggered by an input transition.
- R8: In mode 4 (ordered), match2 is accepted only after a match1 in an earlier cycle has armed it, and acceptance disarms it. A match2 arriving in the same cycle as the arming match1 is ignored, so only event 1 acts. Mode 6 uses the same arming.
- R9: `svc_req` pulses for one cycle, one edge after an accepted match2. Match2 is always accepted in modes 0, 1, 2, 3 and 5.
- R10: In mode 6 (window), the action codes do not drive the pin. A rising input edge while armed drives `pin_out` high, and a rising edge while not armed has no effect.
- R11: In mode 6, an accepted match2 closes the window and samples the input. If the input is high, `pin_out` goes low. Otherwise `pin_out` keeps its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 3 | Channel mode (0 single, 1 blocking, 2 both, 3 match2-only, 4 ordered, 5 user, 6 window) |
| match1 | input | 1 | Match strobe of event 1 |
| match2 | input | 1 | Match strobe of event 2 |
| pin_in | input | 1 | Asynchronous input pin |
| oc1 | input | 3 | Output action code of event 1 |
| ic1 | input | 3 | Input action code of event 1 |
| oc2 | input | 3 | Output action code of event 2 |
| ic2 | input | 3 | Input action code of event 2 |
| m2_blocks_m1 | input | 1 | User-mode priority flag |
| m1_blocks_m2 | input | 1 | User-mode priority flag |
| pin_out | output | 1 | Driven output pin |
| trans1 | output | 1 | Event 1 transition flag |
| trans2 | output | 1 | Event 2 transition flag |
| svc_req | output | 1 | Service request from accepted match2 |

## Verification
The bench sweeps every pair of direct output codes over every priority mode, every user flag pair and both starting pin levels. A wrong priority table would show up as the losing event's action on the pin. Directed cases target three further errors. One is a "no action" winner that fails to suppress a transition-triggered action, which would let the pin move. Another is a 1xx code firing on the bare match. A third is a short-circuit shutoff that leaves the pin high when the input stays low at match2. Window tests check that an edge before the window is ignored, that the close-time sample resets only on a high input, and that an unarmed match2 neither moves the pin nor raises a service request.

// File: rtl/tpa_pkg.sv
package tpa_pkg;

   typedef enum logic [2:0] {
      MODE_SINGLE  = 3'd0,
      MODE_BLOCK   = 3'd1,
      MODE_BOTH    = 3'd2,
      MODE_M2ONLY  = 3'd3,
      MODE_ORDERED = 3'd4,
      MODE_USER    = 3'd5,
      MODE_WINDOW  = 3'd6,
      MODE_RSVD    = 3'd7
   } chan_mode_e;

   typedef enum logic [1:0] {
      ACT_NONE   = 2'd0,
      ACT_HIGH   = 2'd1,
      ACT_LOW    = 2'd2,
      ACT_TOGGLE = 2'd3
   } pin_act_e;

   localparam int CODE_W = 3;

   function automatic pin_act_e code_to_act(input logic [CODE_W-1:0] c);
      case (c)
         3'b001, 3'b101:         return ACT_HIGH;
         3'b010, 3'b110, 3'b100: return ACT_LOW;
         3'b011, 3'b111:         return ACT_TOGGLE;
         default:                return ACT_NONE;
      endcase
   endfunction

   function automatic logic apply_act(input pin_act_e a, input logic lvl);
      case (a)
         ACT_HIGH:   return 1'b1;
         ACT_LOW:    return 1'b0;
         ACT_TOGGLE: return ~lvl;
         default:    return lvl;
      endcase
   endfunction

endpackage

// File: rtl/tpa_sync.sv
module tpa_sync #(
   parameter int STAGES   = 2,
   parameter bit IDLE_LVL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tpa_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{IDLE_LVL}};
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/tpa_event.sv
module tpa_event
   import tpa_pkg::*;
(
   input  logic              match_acc,
   input  logic              in_lvl,
   input  logic              in_rise,
   input  logic              in_fall,
   input  logic [CODE_W-1:0] out_code,
   input  logic [CODE_W-1:0] in_code,
   output logic              occurs,
   output logic              trans,
   output pin_act_e          act
);

   logic fires;

   always_comb begin
      case (in_code)
         3'b001:  trans = in_rise;
         3'b010:  trans = in_fall;
         3'b011:  trans = in_rise | in_fall;
         3'b100:  trans = match_acc & ~in_lvl;
         default: trans = 1'b0;
      endcase
   end

   assign fires  = out_code[CODE_W-1] ? trans : match_acc;
   assign occurs = match_acc | trans;
   assign act    = fires ? code_to_act(out_code) : ACT_NONE;

endmodule

// File: rtl/tpa_resolve.sv
module tpa_resolve
   import tpa_pkg::*;
(
   input  chan_mode_e mode,
   input  logic       occ1,
   input  logic       occ2,
   input  pin_act_e   act1,
   input  pin_act_e   act2,
   input  logic       m2_blocks_m1,
   input  logic       m1_blocks_m2,
   output pin_act_e   act_sel
);

   logic m2_prevails;

   always_comb begin
      case (mode)
         MODE_M2ONLY: m2_prevails = 1'b1;
         MODE_USER:   m2_prevails = m2_blocks_m1 & ~m1_blocks_m2;
         default:     m2_prevails = 1'b0;
      endcase
   end

   always_comb begin
      if (occ1 && occ2) act_sel = m2_prevails ? act2 : act1;
      else if (occ1)    act_sel = act1;
      else if (occ2)    act_sel = act2;
      else              act_sel = ACT_NONE;
   end

endmodule

// File: rtl/tmr_pin_action.sv
module tmr_pin_action
   import tpa_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit RESET_LEVEL = 1'b0,
   parameter bit INPUT_IDLE  = 1'b0,
   parameter bit HAS_WINDOW  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] mode_sel,
   input  logic       match1,
   input  logic       match2,
   input  logic       pin_in,
   input  logic [2:0] oc1,
   input  logic [2:0] ic1,
   input  logic [2:0] oc2,
   input  logic [2:0] ic2,
   input  logic       m2_blocks_m1,
   input  logic       m1_blocks_m2,
   output logic       pin_out,
   output logic       trans1,
   output logic       trans2,
   output logic       svc_req
);

   localparam int NUM_EV = 2;

   chan_mode_e mode;
   assign mode = chan_mode_e'(mode_sel);

   // input synchroniser and edge register
   logic in_s, in_prev_q, in_rise, in_fall;

   tpa_sync #(.STAGES(SYNC_STAGES), .IDLE_LVL(INPUT_IDLE)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(in_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) in_prev_q <= INPUT_IDLE;
      else        in_prev_q <= in_s;
   end

   assign in_rise = in_s & ~in_prev_q;
   assign in_fall = ~in_s & in_prev_q;

   // match2 arming for ordered and window modes
   logic uses_arm, armed_q, m2_acc;
   assign uses_arm = (mode == MODE_ORDERED) || (HAS_WINDOW && mode == MODE_WINDOW);
   assign m2_acc   = match2 & (~uses_arm | armed_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        armed_q <= 1'b0;
      else if (uses_arm) armed_q <= match1 | (armed_q & ~m2_acc);
      else               armed_q <= 1'b0;
   end

   // per-event logic
   logic [CODE_W-1:0] oc_a [NUM_EV];
   logic [CODE_W-1:0] ic_a [NUM_EV];
   logic              mt_a [NUM_EV];
   logic              occ  [NUM_EV];
   logic              trn  [NUM_EV];
   pin_act_e          act  [NUM_EV];

   assign oc_a[0] = oc1;
   assign oc_a[1] = oc2;
   assign ic_a[0] = ic1;
   assign ic_a[1] = ic2;
   assign mt_a[0] = match1;
   assign mt_a[1] = m2_acc;

   generate
      for (genvar e = 0; e < NUM_EV; e++) begin : g_ev
         tpa_event u_ev (
            .match_acc(mt_a[e]),
            .in_lvl   (in_s),
            .in_rise  (in_rise),
            .in_fall  (in_fall),
            .out_code (oc_a[e]),
            .in_code  (ic_a[e]),
            .occurs   (occ[e]),
            .trans    (trn[e]),
            .act      (act[e])
         );
      end
   endgenerate

   pin_act_e code_act;

   tpa_resolve u_resolve (
      .mode        (mode),
      .occ1        (occ[0]),
      .occ2        (occ[1]),
      .act1        (act[0]),
      .act2        (act[1]),
      .m2_blocks_m1(m2_blocks_m1),
      .m1_blocks_m2(m1_blocks_m2),
      .act_sel     (code_act)
   );

   // window variant
   pin_act_e final_act;

   generate
      if (HAS_WINDOW) begin : g_win
         pin_act_e win_act;
         always_comb begin
            if (m2_acc && in_s)        win_act = ACT_LOW;
            else if (armed_q && in_rise) win_act = ACT_HIGH;
            else                       win_act = ACT_NONE;
         end
         assign final_act = (mode == MODE_WINDOW) ? win_act : code_act;
      end else begin : g_nowin
         assign final_act = code_act;
      end
   endgenerate

   // output registers
   logic pin_q, tr1_q, tr2_q, svc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_q <= RESET_LEVEL;
         tr1_q <= 1'b0;
         tr2_q <= 1'b0;
         svc_q <= 1'b0;
      end else begin
         pin_q <= apply_act(final_act, pin_q);
         tr1_q <= trn[0];
         tr2_q <= trn[1];
         svc_q <= m2_acc;
      end
   end

   assign pin_out = pin_q;
   assign trans1  = tr1_q;
   assign trans2  = tr2_q;
   assign svc_req = svc_q;

   // assertions
   assert_svc_R9: assert property (@(posedge clk) disable iff (!rst_n)
      svc_req |-> $past(match2));

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel != 3'd6 && !occ[0] && !occ[1]) |=> $stable(pin_out));

   assert_suppress_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel != 3'd6 && occ[0] && occ[1] &&
       (((mode_sel == 3'd3) || (mode_sel == 3'd5 && m2_blocks_m1 && !m1_blocks_m2))
          ? oc2 : oc1) == 3'b000) |=> $stable(pin_out));

   assert_m2only_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel == 3'd3 && match1 && match2 && oc2 == 3'b001) |=> pin_out);

   assert_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel == 3'd4 && match1 && match2 && !armed_q) |=> !svc_req);

endmodule

// File: tb/tmr_pin_action_tb.sv
`timescale 1ns/1ps
module tmr_pin_action_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] mode_sel = 3'd0;
   logic       match1 = 1'b0, match2 = 1'b0, pin_in = 1'b0;
   logic [2:0] oc1 = 3'd0, ic1 = 3'd0, oc2 = 3'd0, ic2 = 3'd0;
   logic       m2b = 1'b0, m1b = 1'b0;
   logic       pin_out, trans1, trans2, svc_req;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   tmr_pin_action u_dut (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
      .match1(match1), .match2(match2), .pin_in(pin_in),
      .oc1(oc1), .ic1(ic1), .oc2(oc2), .ic2(ic2),
      .m2_blocks_m1(m2b), .m1_blocks_m2(m1b),
      .pin_out(pin_out), .trans1(trans1), .trans2(trans2), .svc_req(svc_req)
   );

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic act_v, input logic exp_v);
      checks++;
      if (act_v !== exp_v) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", req, act_v, exp_v);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; match1 = 0; match2 = 0; pin_in = 0;
      oc1 = 0; ic1 = 0; oc2 = 0; ic2 = 0; mode_sel = 0; m2b = 0; m1b = 0;
      step(); step();
      rst_n = 1'b1;
      step();
   endtask

   // apply input change; returns in the cycle where its edge is visible
   task automatic drive_in(input logic v);
      pin_in = v;
      step(); step();
   endtask

   task automatic set_level(input logic v);
      mode_sel = 3'd0; ic1 = 0; ic2 = 0; oc2 = 0;
      oc1 = v ? 3'b001 : 3'b010;
      match1 = 1; step(); match1 = 0;
   endtask

   function automatic logic model(input logic [2:0] c, input logic lv);
      case (c[1:0])
         2'd1: return 1'b1;
         2'd2: return 1'b0;
         2'd3: return ~lv;
         default: return c[2] ? 1'b0 : lv;
      endcase
   endfunction

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      do_reset();
      // R1 reset state
      chk("R1 pin", pin_out, 1'b0);
      chk("R1 trans1", trans1, 1'b0);
      chk("R1 trans2", trans2, 1'b0);
      chk("R1 svc", svc_req, 1'b0);

      // R2 single-event codes from both levels
      for (int c = 0; c < 4; c++) begin
         for (int lv = 0; lv < 2; lv++) begin
            set_level(lv[0]);
            oc1 = c[2:0]; match1 = 1; step(); match1 = 0;
            chk("R2 single code", pin_out, model(c[2:0], lv[0]));
            step();
            chk("R2 hold", pin_out, model(c[2:0], lv[0]));
         end
      end

      // R5 R6 R7 R8 R9 simultaneous sweep
      for (int m = 0; m < 6; m++) begin
         for (int ub = 0; ub < 4; ub++) begin
            if (m != 5 && ub != 0) continue;
            for (int c1 = 0; c1 < 4; c1++) begin
               for (int c2 = 0; c2 < 4; c2++) begin
                  for (int lv = 0; lv < 2; lv++) begin
                     logic w2;
                     logic [2:0] cw;
                     set_level(lv[0]);
                     mode_sel = m[2:0]; m2b = ub[1]; m1b = ub[0];
                     oc1 = c1[2:0]; oc2 = c2[2:0];
                     match1 = 1; match2 = 1; step(); match1 = 0; match2 = 0;
                     w2 = (m == 3) || (m == 5 && ub == 2);
                     cw = (m == 4) ? c1[2:0] : (w2 ? c2[2:0] : c1[2:0]);
                     if (m == 5)      chk("R6 user priority", pin_out, model(cw, lv[0]));
                     else if (m == 4) chk("R8 ordered simultaneous", pin_out, model(cw, lv[0]));
                     else             chk("R5 mode priority", pin_out, model(cw, lv[0]));
                     chk("R9 svc", svc_req, m != 4);
                     m2b = 0; m1b = 0;
                  end
               end
            end
         end
      end

      // R4 edge-type input codes
      for (int code = 1; code < 4; code++) begin
         for (int e = 0; e < 2; e++) begin
            logic expt;
            do_reset();
            pin_in = e[0] ? 1'b0 : 1'b1;
            step(); step(); step();
            ic1 = code[2:0];
            drive_in(e[0]);
            step();
            expt = (code == 3) || (code == 1 && e == 1) || (code == 2 && e == 0);
            chk("R4 edge trans1", trans1, expt);
            step();
            chk("R4 trans1 pulse", trans1, 1'b0);
         end
      end

      // R4 code 100 samples input at match, also other codes
      do_reset();
      ic2 = 3'b100; match2 = 1; step(); match2 = 0;
      chk("R4 code100 low input", trans2, 1'b1);
      drive_in(1'b1); step();
      match2 = 1; step(); match2 = 0;
      chk("R4 code100 high input", trans2, 1'b0);
      ic2 = 3'b101; match2 = 1; step(); match2 = 0;
      chk("R4 code101 none", trans2, 1'b0);

      // R3 1xx codes wait for the transition
      do_reset();
      oc1 = 3'b101; ic1 = 3'b001;
      match1 = 1; step(); match1 = 0;
      chk("R3 bare match ignored", pin_out, 1'b0);
      drive_in(1'b1); step();
      chk("R3 rise drives high", pin_out, 1'b1);
      oc1 = 3'b111; ic1 = 3'b010;
      drive_in(1'b0); step();
      chk("R3 fall toggles", pin_out, 1'b0);

      // R3 R4 short-circuit shutoff (mode both)
      do_reset();
      mode_sel = 3'd2; oc1 = 3'b001; oc2 = 3'b100; ic2 = 3'b100;
      match1 = 1; step(); match1 = 0;
      chk("R2 turn on", pin_out, 1'b1);
      match2 = 1; step(); match2 = 0;
      chk("R3 shorted shutoff", pin_out, 1'b0);
      chk("R4 shorted trans2", trans2, 1'b1);
      chk("R9 shorted svc", svc_req, 1'b1);
      match1 = 1; step(); match1 = 0;
      drive_in(1'b1); step();
      match2 = 1; step(); match2 = 0;
      chk("R3 healthy stays on", pin_out, 1'b1);
      chk("R4 healthy no trans2", trans2, 1'b0);

      // R7 prevailing no-action suppresses a transition action
      do_reset();
      set_level(1'b1);
      mode_sel = 3'd0; oc1 = 3'b000; oc2 = 3'b110; ic2 = 3'b001;
      drive_in(1'b1);
      match1 = 1; step(); match1 = 0;
      chk("R7 suppressed", pin_out, 1'b1);
      drive_in(1'b0); step();
      mode_sel = 3'd3;
      drive_in(1'b1);
      match1 = 1; step(); match1 = 0;
      chk("R5 event2 prevails transition", pin_out, 1'b0);

      // R8 ordered arming
      do_reset();
      mode_sel = 3'd4; oc2 = 3'b001;
      match2 = 1; step(); match2 = 0;
      chk("R8 unarmed match2 pin", pin_out, 1'b0);
      chk("R8 unarmed match2 svc", svc_req, 1'b0);
      match1 = 1; step(); match1 = 0;
      match2 = 1; step(); match2 = 0;
      chk("R8 armed match2 pin", pin_out, 1'b1);
      chk("R9 armed svc", svc_req, 1'b1);
      oc2 = 3'b010; match2 = 1; step(); match2 = 0;
      chk("R8 disarmed after accept", pin_out, 1'b1);

      // R10 R11 window mode
      do_reset();
      mode_sel = 3'd6; oc1 = 3'b001; oc2 = 3'b001;
      drive_in(1'b1); step();
      chk("R10 edge outside window", pin_out, 1'b0);
      drive_in(1'b0); step();
      match1 = 1; step(); match1 = 0;
      chk("R10 codes ignored", pin_out, 1'b0);
      drive_in(1'b1); step();
      chk("R10 rise in window", pin_out, 1'b1);
      match2 = 1; step(); match2 = 0;
      chk("R11 high sample resets", pin_out, 1'b0);
      chk("R9 window svc", svc_req, 1'b1);
      drive_in(1'b0); step();
      match1 = 1; step(); match1 = 0;
      drive_in(1'b1); step();
      drive_in(1'b0); step();
      match2 = 1; step(); match2 = 0;
      chk("R11 low sample keeps", pin_out, 1'b1);
      match2 = 1; step(); match2 = 0;
      chk("R8 window unarmed pin", pin_out, 1'b1);
      chk("R9 window unarmed svc", svc_req, 1'b0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule